// File: doc/BRIEF.md
# Clock Profile Sequencer with Safe Rollback

This block controls the bring-up and retuning of a configurable reference clock. It holds three settings: profile 0 is the safe setting used at boot and for recovery, profile 1 is the production setting and profile 2 is an alternate mode. Every change runs a fixed chain. The block waits for the supply and the configuration bus to be ready. It then requests a write of the chosen profile and requests a readback with an integrity check. Only after that check passes does it request the apply. It then waits in a settle window until the frequency-in-window flag and the lock flag are both true. Only then does it drive the downstream clock enable. The serial transactions and the oscillator itself sit outside this block and answer through request/done handshakes.

Any step can fail: a handshake that runs past its time limit, a failed integrity check, or a settle window that expires. When a non-safe profile fails, the block starts a new sequence with profile 0, raises a fault flag and a sticky interrupt, stores a 3-bit reason and counts the failure. When a profile-0 sequence fails, no safe setting is left, so the block locks up until reset. After each qualification it records the applied profile, the last qualified profile and the time that profile needed to settle.

Top module: `clk_profile_seq`

## Requirements
- R1: A sequence (boot, host switch or rollback) asserts `cfg_wr_req` only after a clock edge at which `pwr_good` and `bus_ready` were both high. While either is low, no request is issued.
- R2: The requests run strictly in the order write, verify, apply. Each request stays high until its done input arrives. `apply_req` rises only after a `vfy_done` with `vfy_crc_ok` high.
- R3: The block leaves the settle window for the stable state only at an edge where `freq_in_win` and `lock_ok` are both high. Either flag alone has no effect. `time_to_stable` then holds the number of settle cycles before the qualifying one (0 if the first settle cycle qualifies).
- R4: `out_en` is high only in the stable state. It is low from the start of a switch or rollback until qualification.
- R5: Failure reason codes are: 0 none, 1 write timeout, 2 integrity failure (a CRC mismatch, or a verify with no answer within its limit), 3 apply timeout, 4 settle timeout. A handshake times out after WR_TO, VFY_TO or APPLY_TO cycles without done. The settle window times out after `settle_limit` cycles.
- R6: A failure while the target is profile 1 or 2 starts a new sequence with `cfg_profile` = 0 and sets `fault`. `fault` clears only when a later host-requested profile reaches the stable state.
- R7: `irq` is set on every failure and stays high until `int_clr` is pulsed. `reason` keeps the last failure code and is not cleared by `int_clr`.
- R8: `fail_cnt` rises by one on each failure and stops at its maximum (3 for FCW = 2).
- R9: A failure while the target is profile 0 enters a terminal state. In that state `dead` and `fault` stay high, no request or output enable is driven and host switch requests are ignored until reset.
- R10: `active_prof` takes the target profile when apply is acknowledged. `last_good` takes it on entry to the stable state.
- R11: A switch request (`req_valid` with `req_profile`) is accepted only in the stable state. A request for profile code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply of the clock source is valid |
| bus_ready | input | 1 | Configuration bus is usable |
| req_valid | input | 1 | Host requests a profile switch |
| req_profile | input | 2 | Requested profile (0..2) |
| settle_limit | input | TW | Settle window length in cycles |
| int_clr | input | 1 | Pulse clears the interrupt |
| cfg_wr_done | input | 1 | Configuration write finished |
| vfy_done | input | 1 | Readback and integrity check finished |
| vfy_crc_ok | input | 1 | Integrity check result, valid with vfy_done |
| apply_done | input | 1 | Apply acknowledged |
| freq_in_win | input | 1 | Measured frequency is inside its window |
| lock_ok | input | 1 | Lock/ready indication of the source |
| cfg_wr_req | output | 1 | Request to write the profile in cfg_profile |
| vfy_req | output | 1 | Request readback and integrity check |
| apply_req | output | 1 | Request to apply the written profile |
| cfg_profile | output | 2 | Profile the current sequence targets |
| out_en | output | 1 | Downstream clock enable |
| stable | output | 1 | Clock qualified as stable |
| fault | output | 1 | A failure forced a rollback or a lock-up |
| irq | output | 1 | Sticky interrupt |
| reason | output | 3 | Last failure reason code |
| active_prof | output | 2 | Profile last applied |
| last_good | output | 2 | Profile last qualified stable |
| fail_cnt | output | FCW | Saturating failure count |
| time_to_stable | output | TW | Settle cycles before last qualification |
| dead | output | 1 | Terminal fault state |

## Verification
The bench first holds each readiness input low on its own, then boots the safe profile. Next, a table of switch scenarios sends each step of the chain into each of its failure modes: write timeout, verify timeout, CRC mismatch, apply timeout and settle timeout. Each failure is interleaved with clean switches to profiles 1 and 2, so the stored reason, the rollback target, the fault-clearing rule and the counter saturation can be told apart from one another. During each settle window the two qualification flags are driven high one at a time, in alternation, before both are raised together. This shows that one flag alone never qualifies and that the settle-time record counts exactly. Directed cases cover an invalid profile request and a failed rollback that drives the block into the terminal state.

// File: rtl/cps_pkg.sv
package cps_pkg;
    typedef enum logic [2:0] {
        S_WAIT   = 3'd0,
        S_WRITE  = 3'd1,
        S_VFY    = 3'd2,
        S_APPLY  = 3'd3,
        S_SETTLE = 3'd4,
        S_STABLE = 3'd5,
        S_DEAD   = 3'd6
    } seq_state_e;

    typedef logic [1:0] prof_t;

    localparam prof_t SAFE_PROF = 2'd0;

    localparam logic [2:0] RC_NONE   = 3'd0;
    localparam logic [2:0] RC_WRITE  = 3'd1;
    localparam logic [2:0] RC_CRC    = 3'd2;
    localparam logic [2:0] RC_APPLY  = 3'd3;
    localparam logic [2:0] RC_SETTLE = 3'd4;
endpackage

// File: rtl/cps_timer.sv
module cps_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [TW-1:0] count
);
    localparam logic [TW-1:0] CMAX = {TW{1'b1}};

    logic [TW-1:0] count_d, count_q;

    always_comb begin
        if (clear)
            count_d = '0;
        else if (count_q != CMAX)
            count_d = count_q + 1'b1;
        else
            count_d = count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/cps_satcnt.sv
module cps_satcnt #(
    parameter int FCW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inc,
    output logic [FCW-1:0] value
);
    localparam logic [FCW-1:0] VMAX = {FCW{1'b1}};

    logic [FCW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != VMAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;

    AST_FCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == VMAX) |=> (cnt_q == VMAX)); // R8
    AST_FCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> (cnt_q == FCW'($past(cnt_q) + 1'b1))); // R8
endmodule

// File: rtl/clk_profile_seq.sv
module clk_profile_seq
    import cps_pkg::*;
#(
    parameter int TW       = 16,
    parameter int FCW      = 2,
    parameter int WR_TO    = 64,
    parameter int VFY_TO   = 64,
    parameter int APPLY_TO = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_good,
    input  logic           bus_ready,
    input  logic           req_valid,
    input  logic [1:0]     req_profile,
    input  logic [TW-1:0]  settle_limit,
    input  logic           int_clr,
    input  logic           cfg_wr_done,
    input  logic           vfy_done,
    input  logic           vfy_crc_ok,
    input  logic           apply_done,
    input  logic           freq_in_win,
    input  logic           lock_ok,
    output logic           cfg_wr_req,
    output logic           vfy_req,
    output logic           apply_req,
    output logic [1:0]     cfg_profile,
    output logic           out_en,
    output logic           stable,
    output logic           fault,
    output logic           irq,
    output logic [2:0]     reason,
    output logic [1:0]     active_prof,
    output logic [1:0]     last_good,
    output logic [FCW-1:0] fail_cnt,
    output logic [TW-1:0]  time_to_stable,
    output logic           dead
);
    localparam logic [TW-1:0] WR_LIM    = TW'(WR_TO);
    localparam logic [TW-1:0] VFY_LIM   = TW'(VFY_TO);
    localparam logic [TW-1:0] APPLY_LIM = TW'(APPLY_TO);

    typedef struct packed {
        seq_state_e    st;
        prof_t         tgt;
        logic          rb;
        logic          fault;
        logic          irq;
        logic [2:0]    reason;
        prof_t         active;
        prof_t         good;
        logic [TW-1:0] tts;
    } seq_regs_t;

    seq_regs_t     r_q, r_d;
    logic [TW-1:0] tcount;
    logic [TW-1:0] lim;
    logic [TW:0]   tnext;
    logic          tmo;
    logic          fail;
    logic [2:0]    fcode;
    logic          tclr;

    cps_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tclr),
        .count (tcount)
    );

    cps_satcnt #(.FCW(FCW)) u_fcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fail),
        .value (fail_cnt)
    );

    always_comb begin
        case (r_q.st)
            S_WRITE: lim = WR_LIM;
            S_VFY:   lim = VFY_LIM;
            S_APPLY: lim = APPLY_LIM;
            default: lim = settle_limit;
        endcase
        tnext = {1'b0, tcount} + 1'b1;
        tmo   = (tnext >= {1'b0, lim});
    end

    always_comb begin
        r_d   = r_q;
        fail  = 1'b0;
        fcode = RC_NONE;
        case (r_q.st)
            S_WAIT: begin
                if (pwr_good && bus_ready) r_d.st = S_WRITE;
            end
            S_WRITE: begin
                if (cfg_wr_done) r_d.st = S_VFY;
                else if (tmo) begin fail = 1'b1; fcode = RC_WRITE; end
            end
            S_VFY: begin
                if (vfy_done) begin
                    if (vfy_crc_ok) r_d.st = S_APPLY;
                    else begin fail = 1'b1; fcode = RC_CRC; end
                end else if (tmo) begin
                    fail = 1'b1; fcode = RC_CRC;
                end
            end
            S_APPLY: begin
                if (apply_done) begin
                    r_d.st     = S_SETTLE;
                    r_d.active = r_q.tgt;
                end else if (tmo) begin
                    fail = 1'b1; fcode = RC_APPLY;
                end
            end
            S_SETTLE: begin
                if (freq_in_win && lock_ok) begin
                    r_d.st   = S_STABLE;
                    r_d.good = r_q.tgt;
                    r_d.tts  = tcount;
                    if (!r_q.rb) r_d.fault = 1'b0;
                end else if (tmo) begin
                    fail = 1'b1; fcode = RC_SETTLE;
                end
            end
            S_STABLE: begin
                if (req_valid && req_profile != 2'd3) begin
                    r_d.st  = S_WAIT;
                    r_d.tgt = req_profile;
                    r_d.rb  = 1'b0;
                end
            end
            default: r_d.st = S_DEAD;
        endcase

        if (fail) begin
            r_d.reason = fcode;
            r_d.irq    = 1'b1;
            r_d.fault  = 1'b1;
            if (r_q.tgt == SAFE_PROF) begin
                r_d.st = S_DEAD;
            end else begin
                r_d.st  = S_WAIT;
                r_d.tgt = SAFE_PROF;
                r_d.rb  = 1'b1;
            end
        end else if (int_clr) begin
            r_d.irq = 1'b0;
        end

        tclr = (r_d.st != r_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_WAIT, tgt: SAFE_PROF, rb: 1'b0, fault: 1'b0,
                     irq: 1'b0, reason: RC_NONE, active: SAFE_PROF,
                     good: SAFE_PROF, tts: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_wr_req     = (r_q.st == S_WRITE);
    assign vfy_req        = (r_q.st == S_VFY);
    assign apply_req      = (r_q.st == S_APPLY);
    assign stable         = (r_q.st == S_STABLE);
    assign out_en         = (r_q.st == S_STABLE);
    assign dead           = (r_q.st == S_DEAD);
    assign cfg_profile    = r_q.tgt;
    assign fault          = r_q.fault;
    assign irq            = r_q.irq;
    assign reason         = r_q.reason;
    assign active_prof    = r_q.active;
    assign last_good      = r_q.good;
    assign time_to_stable = r_q.tts;

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr_req) |-> $past(pwr_good && bus_ready)); // R1
    AST_APPLY_AFTER_VFY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(apply_req) |-> $past(vfy_done && vfy_crc_ok)); // R2
    AST_STABLE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable) |-> $past(freq_in_win && lock_ok)); // R3
    AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> ($past(out_en) || $past(freq_in_win && lock_ok))); // R4
    AST_REASON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reason) |-> irq); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !int_clr) |=> irq); // R7
    AST_DEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dead |=> (dead && fault && !cfg_wr_req && !out_en)); // R9
endmodule

// File: tb/tb_clk_profile_seq.sv
module tb_clk_profile_seq;
    localparam int TW  = 8;
    localparam int FCW = 2;
    localparam int NV  = 8;
    // kinds: 0 ok, 1 write timeout, 2 crc fail, 3 apply timeout, 4 settle timeout, 5 verify timeout
    localparam int V_PROF [NV] = '{1, 2, 2, 1, 1, 2, 1, 1};
    localparam int V_KIND [NV] = '{0, 2, 0, 1, 5, 3, 4, 0};
    localparam int V_D    [NV] = '{3, 0, 0, 0, 0, 0, 0, 5};
    localparam int V_RC   [NV] = '{0, 2, 0, 1, 2, 3, 4, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, bus_ready = 1'b0, req_valid = 1'b0, int_clr = 1'b0;
    logic [1:0] req_profile = 2'd0;
    logic [TW-1:0] settle_limit = 8'd12;
    logic cfg_wr_done = 1'b0, vfy_done = 1'b0, vfy_crc_ok = 1'b0, apply_done = 1'b0;
    logic freq_in_win = 1'b0, lock_ok = 1'b0;
    logic cfg_wr_req, vfy_req, apply_req, out_en, stable, fault, irq, dead;
    logic [1:0] cfg_profile, active_prof, last_good;
    logic [2:0] reason;
    logic [FCW-1:0] fail_cnt;
    logic [TW-1:0] time_to_stable;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    int exp_rc = 0;

    always #2 clk = ~clk;

    clk_profile_seq #(.TW(TW), .FCW(FCW), .WR_TO(8), .VFY_TO(8), .APPLY_TO(8)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .bus_ready(bus_ready),
        .req_valid(req_valid), .req_profile(req_profile), .settle_limit(settle_limit),
        .int_clr(int_clr), .cfg_wr_done(cfg_wr_done), .vfy_done(vfy_done),
        .vfy_crc_ok(vfy_crc_ok), .apply_done(apply_done), .freq_in_win(freq_in_win),
        .lock_ok(lock_ok), .cfg_wr_req(cfg_wr_req), .vfy_req(vfy_req),
        .apply_req(apply_req), .cfg_profile(cfg_profile), .out_en(out_en),
        .stable(stable), .fault(fault), .irq(irq), .reason(reason),
        .active_prof(active_prof), .last_good(last_good), .fail_cnt(fail_cnt),
        .time_to_stable(time_to_stable), .dead(dead)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_seq(input int prof, input int kind, input int d);
        freq_in_win = 1'b0;
        lock_ok = 1'b0;
        while (!cfg_wr_req) @(negedge clk);
        chk("R6 target profile of sequence", cfg_profile, prof);
        chk("R4 enable off while writing", out_en, 0);
        if (kind == 1) begin
            while (cfg_wr_req) @(negedge clk);
            return;
        end
        cfg_wr_done = 1'b1;
        @(negedge clk);
        cfg_wr_done = 1'b0;
        chk("R2 verify follows write", vfy_req, 1);
        chk("R2 no apply before verify", apply_req, 0);
        if (kind == 5) begin
            while (vfy_req) @(negedge clk);
            return;
        end
        vfy_done = 1'b1;
        vfy_crc_ok = (kind != 2);
        @(negedge clk);
        vfy_done = 1'b0;
        vfy_crc_ok = 1'b0;
        if (kind == 2) begin
            chk("R2 no apply after CRC mismatch", apply_req, 0);
            return;
        end
        chk("R2 apply after verify pass", apply_req, 1);
        if (kind == 3) begin
            while (apply_req) @(negedge clk);
            return;
        end
        apply_done = 1'b1;
        @(negedge clk);
        apply_done = 1'b0;
        chk("R10 active profile on apply", active_prof, prof);
        if (kind == 4) return;
        for (int i = 0; i < d; i++) begin
            freq_in_win = (i % 2 == 0);
            lock_ok = (i % 2 == 1);
            @(negedge clk);
            chk("R3 single flag does not qualify", stable, 0);
            chk("R4 enable off during settle", out_en, 0);
        end
        freq_in_win = 1'b1;
        lock_ok = 1'b1;
        @(negedge clk);
        chk("R3 stable on both flags", stable, 1);
        chk("R4 enable after qualification", out_en, 1);
        chk("R3 time to stable", time_to_stable, d);
        chk("R10 last good profile", last_good, prof);
    endtask

    task automatic request(input int prof);
        req_profile = prof[1:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual 50000 cycles expected fewer");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset out_en", out_en, 0);
        chk("reset irq", irq, 0);
        chk("reset fault", fault, 0);
        chk("reset reason", reason, 0);
        chk("reset fail_cnt", fail_cnt, 0);

        pwr_good = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R1 no write without bus_ready", cfg_wr_req, 0);
        end
        pwr_good = 1'b0;
        bus_ready = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R1 no write without pwr_good", cfg_wr_req, 0);
        end
        pwr_good = 1'b1;
        run_seq(0, 0, 2);
        chk("R6 boot has no fault", fault, 0);

        for (int v = 0; v < NV; v++) begin
            request(V_PROF[v]);
            run_seq(V_PROF[v], V_KIND[v], V_D[v]);
            if (V_KIND[v] != 0) begin
                exp_rc = V_RC[v];
                if (exp_cnt < 3) exp_cnt++;
                run_seq(0, 0, 2);
                chk("R6 rollback active profile", active_prof, 0);
                chk("R6 fault after rollback", fault, 1);
                chk("R5 reason code", reason, exp_rc);
                chk("R7 irq raised", irq, 1);
                chk("R8 failure count", fail_cnt, exp_cnt);
                int_clr = 1'b1;
                @(negedge clk);
                int_clr = 1'b0;
                chk("R7 irq cleared", irq, 0);
                chk("R7 reason kept after clear", reason, exp_rc);
            end else begin
                chk("R6 fault cleared by host switch", fault, 0);
                chk("R10 active profile", active_prof, V_PROF[v]);
                chk("R8 failure count unchanged", fail_cnt, exp_cnt);
                chk("R7 reason kept", reason, exp_rc);
            end
        end

        request(3);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R11 profile 3 ignored (no write)", cfg_wr_req, 0);
        end
        chk("R11 still stable", stable, 1);

        request(2);
        run_seq(2, 2, 0);
        run_seq(0, 1, 0);
        @(negedge clk);
        chk("R9 terminal state", dead, 1);
        chk("R9 fault held", fault, 1);
        chk("R9 output disabled", out_en, 0);
        chk("R5 reason of rollback failure", reason, 1);
        chk("R8 count saturated", fail_cnt, 3);
        request(1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R9 request ignored when dead", cfg_wr_req, 0);
        end
        chk("R9 still dead", dead, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule